// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Outputs

A purely combinational arithmetic-logic unit for a small accumulator-style processor. Each cycle it receives a four-bit operation code, the register value (accumulator or index register), an operand byte and the present carry flag. It returns the result byte, the next values of the carry, zero, overflow and negative flags, and a four-bit mask that tells the surrounding datapath which of those flags the operation actually writes. Flags outside the mask keep their stored value in the flag register, which lives outside this block.

Arithmetic is binary only. Subtraction treats carry as an inverted borrow. Compare and bit test change only flags; their result output echoes the register input so that a write-back mux needs no special case. One shared adder serves add, subtract, compare, increment and decrement. One shared shifter serves the four shift and rotate forms.

Top module: `alu8_core`

## Requirements
- R1: Add (code 0) returns the low 8 bits of register + operand + carry_i; flag_c is bit 8 of that 9-bit sum.
- R2: For add, flag_v is 1 exactly when register and operand have equal bit 7 and the result's bit 7 differs from them.
- R3: Subtract (code 1) returns register − operand − (1 − carry_i) modulo 256; flag_c is 1 when no borrow occurred; flag_v is 1 when register and operand differ in bit 7 and the result's bit 7 differs from the register's.
- R4: Compare (code 5) sets flag_c when register ≥ operand (unsigned), flag_z when equal, flag_n from bit 7 of (register − operand) mod 256; the result equals the register input and the V mask bit is 0.
- R5: Bit test (code 6) sets flag_z when (register AND operand) is 0, copies operand bit 6 to flag_v and bit 7 to flag_n, and the result equals the register input.
- R6: AND (code 2), OR (code 3) and XOR (code 4) return the bitwise function and write only Z and N (mask 4'b1010).
- R7: Shift left (code 7) moves bit 7 into flag_c and fills bit 0 with 0; logical shift right (code 8) moves bit 0 into flag_c, fills bit 7 with 0 and gives flag_n = 0.
- R8: Rotate left (code 9) puts carry_i into bit 0 and old bit 7 into flag_c; rotate right (code 10) puts carry_i into bit 7 and old bit 0 into flag_c.
- R9: Increment (code 11) and decrement (code 12) wrap modulo 256 and write only Z and N (mask 4'b1010), independent of carry_i.
- R10: Mask bit 0 is C, bit 1 is Z, bit 2 is V, bit 3 is N; add and subtract write all four (4'b1111), compare and shifts write C, Z, N (4'b1011), bit test writes Z, V, N (4'b1110); any flag output whose mask bit is 0 is driven 0.
- R11: Codes 13 to 15 return the register input unchanged with mask 4'b0000.
- R12: Wherever Z is written by a result-producing operation, flag_z is 1 exactly when the result byte is 0, and flag_n equals result bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| reg_i | input | 8 | Register (accumulator or index) value |
| opnd_i | input | 8 | Operand byte |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Result byte |
| flag_c_o | output | 1 | Next carry flag |
| flag_z_o | output | 1 | Next zero flag |
| flag_v_o | output | 1 | Next overflow flag |
| flag_n_o | output | 1 | Next negative flag |
| upd_mask_o | output | 4 | Flags written by this operation (bit0 C, bit1 Z, bit2 V, bit3 N) |

## Verification
The assertions inside the top module are immediate checks on a combinational cone and take for granted that every input is a known 0/1 value; they skip evaluation while any input carries X or Z. The bench drives all four inputs together on the falling clock edge from a defined value at time zero, so no check ever sees a partially updated or unknown input. The directed scenarios target sign-boundary overflow, borrow with carry clear, equal and unequal compares, carry entering each rotate, wrap-around of increment and decrement, and the unused codes.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes and flag mask positions for the ALU.
// Assumes: the operation code is four bits wide; codes 13..15 are unused.
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_CMP = 4'd5,
        OP_BIT = 4'd6,
        OP_SHL = 4'd7,
        OP_SHR = 4'd8,
        OP_ROL = 4'd9,
        OP_ROR = 4'd10,
        OP_INC = 4'd11,
        OP_DEC = 4'd12
    } alu_op_e;

    // Flag positions inside the update mask
    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_V = 2;
    localparam int FLAG_N = 3;
    localparam int NFLAGS = 4;

    // Canned masks for the operation groups
    localparam logic [NFLAGS-1:0] MASK_ALL  = 4'b1111;
    localparam logic [NFLAGS-1:0] MASK_ZN   = 4'b1010;
    localparam logic [NFLAGS-1:0] MASK_CZN  = 4'b1011;
    localparam logic [NFLAGS-1:0] MASK_ZVN  = 4'b1110;
    localparam logic [NFLAGS-1:0] MASK_NONE = 4'b0000;

    // Bitwise function select
    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2
    } bw_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
// Module: ripple-free binary adder with carry in/out and signed overflow.
// Assumes: the caller pre-inverts b_i for subtraction and compare, so one
// overflow rule (equal input signs, differing result sign) covers both.
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide_sum;

    // Purpose: form the WIDTH+1 bit sum of both inputs and the carry
    always_comb begin
        wide_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    end

    assign sum_o  = wide_sum[WIDTH-1:0];
    assign cout_o = wide_sum[WIDTH];

    // Purpose: signed overflow from operand and result sign bits
    always_comb begin
        ovf_o = (a_i[MSB] == b_i[MSB]) && (wide_sum[MSB] != a_i[MSB]);
    end

endmodule

// File: rtl/alu8_shift.sv
// Module: single-position shifter serving shift-left, shift-right and both
// rotates through carry.
// Assumes: the caller passes 0 as fill_i for plain shifts and the carry
// flag for rotates.
module alu8_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic             fill_i,
    input  logic             left_i,
    output logic [WIDTH-1:0] res_o,
    output logic             out_bit_o
);
    localparam int MSB = WIDTH - 1;

    // Purpose: pick the bit that leaves the word
    always_comb begin
        out_bit_o = left_i ? val_i[MSB] : val_i[0];
    end

    // Purpose: move each bit one place, the fill entering at the open end
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_low
            assign res_o[i] = left_i ? fill_i : val_i[i+1];
        end else if (i == MSB) begin : g_high
            assign res_o[i] = left_i ? val_i[i-1] : fill_i;
        end else begin : g_mid
            assign res_o[i] = left_i ? val_i[i-1] : val_i[i+1];
        end
    end

endmodule

// File: rtl/alu8_bitwise.sv
// Module: per-bit AND / OR / XOR unit.
// Assumes: the unused select code behaves as AND.
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  bw_sel_e          sel_i,
    output logic [WIDTH-1:0] res_o
);
    // Purpose: one small gate selector per bit position
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        always_comb begin
            unique case (sel_i)
                BW_OR:   res_o[i] = a_i[i] | b_i[i];
                BW_XOR:  res_o[i] = a_i[i] ^ b_i[i];
                default: res_o[i] = a_i[i] & b_i[i];
            endcase
        end
    end

endmodule

// File: rtl/alu8_core.sv
// Module: top of the accumulator ALU. Decodes the operation code, steers the
// shared adder, shifter and bitwise unit, and assembles result, next flags
// and the flag update mask.
// Assumes: purely combinational; flag storage and decimal mode live
// elsewhere; flags outside the mask are driven 0.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] reg_i,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             flag_c_o,
    output logic             flag_z_o,
    output logic             flag_v_o,
    output logic             flag_n_o,
    output logic [3:0]       upd_mask_o
);
    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ALL_ZERO = {WIDTH{1'b0}};

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    // Shared unit control and outputs
    logic [WIDTH-1:0] add_b;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic             add_ovf;
    logic             sh_left;
    logic             sh_fill;
    logic [WIDTH-1:0] sh_res;
    logic             sh_out;
    bw_sel_e          bw_sel;
    logic [WIDTH-1:0] bw_res;

    // Purpose: set the adder's second input and carry for each arithmetic op
    always_comb begin
        add_b   = opnd_i;
        add_cin = carry_i;
        unique case (op)
            OP_SUB: begin add_b = ~opnd_i;  add_cin = carry_i; end
            OP_CMP: begin add_b = ~opnd_i;  add_cin = 1'b1;    end
            OP_INC: begin add_b = ALL_ZERO; add_cin = 1'b1;    end
            OP_DEC: begin add_b = ALL_ONES; add_cin = 1'b0;    end
            default: begin add_b = opnd_i;  add_cin = carry_i; end
        endcase
    end

    // Purpose: choose shift direction and the bit entering the open end
    always_comb begin
        sh_left = (op == OP_SHL) || (op == OP_ROL);
        sh_fill = ((op == OP_ROL) || (op == OP_ROR)) ? carry_i : 1'b0;
    end

    // Purpose: choose the bitwise function
    always_comb begin
        unique case (op)
            OP_OR:   bw_sel = BW_OR;
            OP_XOR:  bw_sel = BW_XOR;
            default: bw_sel = BW_AND;
        endcase
    end

    alu8_addsub #(.WIDTH(WIDTH)) u_add (
        .a_i   (reg_i),
        .b_i   (add_b),
        .cin_i (add_cin),
        .sum_o (add_sum),
        .cout_o(add_cout),
        .ovf_o (add_ovf)
    );

    alu8_shift #(.WIDTH(WIDTH)) u_shift (
        .val_i    (reg_i),
        .fill_i   (sh_fill),
        .left_i   (sh_left),
        .res_o    (sh_res),
        .out_bit_o(sh_out)
    );

    alu8_bitwise #(.WIDTH(WIDTH)) u_bw (
        .a_i  (reg_i),
        .b_i  (opnd_i),
        .sel_i(bw_sel),
        .res_o(bw_res)
    );

    // Purpose: route the active unit to the outputs and form flags and mask
    always_comb begin
        result_o   = reg_i;
        flag_c_o   = 1'b0;
        flag_z_o   = 1'b0;
        flag_v_o   = 1'b0;
        flag_n_o   = 1'b0;
        upd_mask_o = MASK_NONE;
        unique case (op)
            OP_ADD, OP_SUB: begin
                result_o   = add_sum;
                flag_c_o   = add_cout;
                flag_v_o   = add_ovf;
                flag_z_o   = (add_sum == ALL_ZERO);
                flag_n_o   = add_sum[MSB];
                upd_mask_o = MASK_ALL;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result_o   = bw_res;
                flag_z_o   = (bw_res == ALL_ZERO);
                flag_n_o   = bw_res[MSB];
                upd_mask_o = MASK_ZN;
            end
            OP_CMP: begin
                flag_c_o   = add_cout;
                flag_z_o   = (add_sum == ALL_ZERO);
                flag_n_o   = add_sum[MSB];
                upd_mask_o = MASK_CZN;
            end
            OP_BIT: begin
                flag_z_o   = (bw_res == ALL_ZERO);
                flag_v_o   = opnd_i[MSB-1];
                flag_n_o   = opnd_i[MSB];
                upd_mask_o = MASK_ZVN;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                result_o   = sh_res;
                flag_c_o   = sh_out;
                flag_z_o   = (sh_res == ALL_ZERO);
                flag_n_o   = sh_res[MSB];
                upd_mask_o = MASK_CZN;
            end
            OP_INC, OP_DEC: begin
                result_o   = add_sum;
                flag_z_o   = (add_sum == ALL_ZERO);
                flag_n_o   = add_sum[MSB];
                upd_mask_o = MASK_ZN;
            end
            default: begin
                result_o   = reg_i;
                upd_mask_o = MASK_NONE;
            end
        endcase
    end

    // Purpose: guard flag and result relations at the block's outputs
    always_comb begin
        if (!$isunknown({op_i, reg_i, opnd_i, carry_i})) begin
            // R2: add overflow only when input signs agree and result sign flips
            p_add_ovf_sign_r2: assert (!(op == OP_ADD && flag_v_o) ||
                ((reg_i[MSB] == opnd_i[MSB]) && (result_o[MSB] != reg_i[MSB])))
                else $error("add overflow with incompatible signs");
            // R4: compare leaves the register and never writes V
            p_cmp_keeps_reg_r4: assert (!(op == OP_CMP) ||
                ((result_o == reg_i) && !upd_mask_o[FLAG_V]))
                else $error("compare altered register or wrote V");
            // R5: bit test copies operand top bits into N and V
            p_bit_copy_r5: assert (!(op == OP_BIT) ||
                ((flag_n_o == opnd_i[MSB]) && (flag_v_o == opnd_i[MSB-1])))
                else $error("bit test flag copy wrong");
            // R6: logic ops write only Z and N
            p_logic_mask_r6: assert (!(op == OP_AND || op == OP_OR || op == OP_XOR) ||
                (upd_mask_o == MASK_ZN))
                else $error("logic op mask wrong");
            // R7: logical right shift never sets negative
            p_shr_neg_clear_r7: assert (!(op == OP_SHR) || !flag_n_o)
                else $error("shift right set N");
            // R9: increment/decrement never write carry or overflow
            p_incdec_mask_r9: assert (!(op == OP_INC || op == OP_DEC) ||
                (!upd_mask_o[FLAG_C] && !upd_mask_o[FLAG_V]))
                else $error("inc/dec wrote C or V");
            // R10: unwritten flags are driven low
            p_unwritten_low_r10: assert (({flag_n_o, flag_v_o, flag_z_o, flag_c_o} & ~upd_mask_o) == 4'b0000)
                else $error("flag outside mask is high");
            // R12: Z and N follow the result for result-producing ops
            p_zn_follow_r12: assert (!(upd_mask_o[FLAG_Z] && op != OP_CMP && op != OP_BIT) ||
                ((flag_z_o == (result_o == ALL_ZERO)) && (flag_n_o == result_o[MSB])))
                else $error("Z/N not derived from result");
        end
    end

endmodule

// File: tb/sim_alu8_core.sv
// Directed bench for alu8_core; expected values come from a separate
// reference function written from the requirements.
module sim_alu8_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] ra = 8'd0;
    logic [7:0] rm = 8'd0;
    logic       ci = 1'b0;
    logic [7:0] res;
    logic       fc, fz, fv, fn;
    logic [3:0] msk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core u0 (
        .op_i(op), .reg_i(ra), .opnd_i(rm), .carry_i(ci),
        .result_o(res), .flag_c_o(fc), .flag_z_o(fz), .flag_v_o(fv),
        .flag_n_o(fn), .upd_mask_o(msk)
    );

    // Reference model: returns {result, n, v, z, c, mask}
    function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] a,
                                          input logic [7:0] m, input logic c);
        int s; logic [7:0] r; logic fcx, fzx, fvx, fnx; logic [3:0] k;
        r = a; fcx = 0; fzx = 0; fvx = 0; fnx = 0; k = 4'b0000;
        case (o)
            4'd0: begin s = int'(a) + int'(m) + int'(c); r = s[7:0]; fcx = s > 255;
                  fvx = (a[7] == m[7]) && (r[7] != a[7]); k = 4'b1111; end
            4'd1: begin s = int'(a) - int'(m) - (c ? 0 : 1); r = s[7:0]; fcx = s >= 0;
                  fvx = (a[7] != m[7]) && (r[7] != a[7]); k = 4'b1111; end
            4'd2: begin r = a & m; k = 4'b1010; end
            4'd3: begin r = a | m; k = 4'b1010; end
            4'd4: begin r = a ^ m; k = 4'b1010; end
            4'd5: begin fcx = a >= m; fzx = a == m; fnx = (a - m) >> 7; k = 4'b1011; end
            4'd6: begin fzx = (a & m) == 0; fvx = m[6]; fnx = m[7]; k = 4'b1110; end
            4'd7: begin r = {a[6:0], 1'b0}; fcx = a[7]; k = 4'b1011; end
            4'd8: begin r = {1'b0, a[7:1]}; fcx = a[0]; k = 4'b1011; end
            4'd9: begin r = {a[6:0], c}; fcx = a[7]; k = 4'b1011; end
            4'd10: begin r = {c, a[7:1]}; fcx = a[0]; k = 4'b1011; end
            4'd11: begin r = a + 8'd1; k = 4'b1010; end
            4'd12: begin r = a - 8'd1; k = 4'b1010; end
            default: begin r = a; k = 4'b0000; end
        endcase
        if (o != 4'd5 && o != 4'd6 && k[1]) begin fzx = (r == 0); fnx = r[7]; end
        return {r, fnx, fvx, fzx, fcx, k};
    endfunction

    // Apply one vector away from the clock edge and compare every output
    task automatic apply(input string tag, input logic [3:0] o, input logic [7:0] a,
                         input logic [7:0] m, input logic c);
        logic [15:0] exp, got;
        @(negedge clk);
        op = o; ra = a; rm = m; ci = c;
        #1;
        exp = model(o, a, m, c);
        got = {res, fn, fv, fz, fc, msk};
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s op=%0d a=%02h m=%02h c=%0b: got res=%02h nvzc=%04b mask=%04b expected res=%02h nvzc=%04b mask=%04b",
                     tag, o, a, m, c, got[15:8], got[7:4], got[3:0], exp[15:8], exp[7:4], exp[3:0]);
        end
    endtask

    // Reset/idle state: the initial vector is a zero add
    task automatic t_initial;
        #1;
        n_checks++;
        if ({res, fn, fv, fz, fc, msk} !== {8'h00, 4'b0010, 4'b1111}) begin
            n_fails++;
            $display("FAIL R1 initial: got res=%02h nvzc=%b%b%b%b mask=%04b expected res=00 nvzc=0010 mask=1111",
                     res, fn, fv, fz, fc, msk);
        end
    endtask

    task automatic t_add;
        apply("R1", 4'd0, 8'h12, 8'h34, 1'b0);
        apply("R1", 4'd0, 8'h12, 8'h34, 1'b1);
        apply("R1", 4'd0, 8'hFF, 8'h01, 1'b0);
        apply("R2", 4'd0, 8'h7F, 8'h01, 1'b0);
        apply("R2", 4'd0, 8'h80, 8'h80, 1'b0);
        apply("R2", 4'd0, 8'h80, 8'h7F, 1'b1);
    endtask

    task automatic t_sub;
        apply("R3", 4'd1, 8'h05, 8'h03, 1'b1);
        apply("R3", 4'd1, 8'h05, 8'h03, 1'b0);
        apply("R3", 4'd1, 8'h50, 8'hF0, 1'b1);
        apply("R3", 4'd1, 8'h50, 8'hB0, 1'b1);
        apply("R3", 4'd1, 8'h00, 8'h00, 1'b0);
        apply("R3", 4'd1, 8'h80, 8'h01, 1'b1);
    endtask

    task automatic t_cmp;
        apply("R4", 4'd5, 8'h40, 8'h40, 1'b0);
        apply("R4", 4'd5, 8'h41, 8'h40, 1'b0);
        apply("R4", 4'd5, 8'h10, 8'h90, 1'b1);
        apply("R4", 4'd5, 8'h00, 8'hFF, 1'b1);
    endtask

    task automatic t_bit;
        apply("R5", 4'd6, 8'h0F, 8'hF0, 1'b0);
        apply("R5", 4'd6, 8'hFF, 8'h40, 1'b1);
        apply("R5", 4'd6, 8'h01, 8'h81, 1'b0);
    endtask

    task automatic t_logic;
        apply("R6", 4'd2, 8'hF0, 8'h0F, 1'b1);
        apply("R6", 4'd3, 8'h80, 8'h01, 1'b1);
        apply("R6", 4'd4, 8'hAA, 8'hAA, 1'b0);
        apply("R6", 4'd4, 8'hA5, 8'h0F, 1'b1);
    endtask

    task automatic t_shift;
        apply("R7", 4'd7, 8'h81, 8'h00, 1'b1);
        apply("R7", 4'd7, 8'h80, 8'h00, 1'b0);
        apply("R7", 4'd8, 8'h81, 8'h00, 1'b1);
        apply("R7", 4'd8, 8'h01, 8'h00, 1'b0);
    endtask

    task automatic t_rotate;
        apply("R8", 4'd9, 8'h80, 8'h00, 1'b0);
        apply("R8", 4'd9, 8'h40, 8'h00, 1'b1);
        apply("R8", 4'd10, 8'h01, 8'h00, 1'b0);
        apply("R8", 4'd10, 8'h02, 8'h00, 1'b1);
    endtask

    task automatic t_incdec;
        apply("R9", 4'd11, 8'hFF, 8'h12, 1'b1);
        apply("R9", 4'd11, 8'h7F, 8'h00, 1'b0);
        apply("R9", 4'd12, 8'h00, 8'h00, 1'b1);
        apply("R9", 4'd12, 8'h01, 8'hFF, 1'b0);
    endtask

    task automatic t_unused;
        for (int k = 13; k < 16; k++) begin
            apply("R11", 4'(k), 8'h9C, 8'h55, 1'b1);
        end
    endtask

    // Mask layout and zero/negative rules over a sweep of all codes
    task automatic t_sweep;
        for (int k = 0; k < 16; k++) begin
            apply("R10", 4'(k), 8'h00, 8'h00, 1'b0);
            apply("R12", 4'(k), 8'hC3, 8'h3C, 1'b1);
        end
    endtask

    initial begin
        t_initial();
        t_add();
        t_sub();
        t_cmp();
        t_bit();
        t_logic();
        t_shift();
        t_rotate();
        t_incdec();
        t_unused();
        t_sweep();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_fails++;
                    $display("FAIL watchdog: got timeout expected completion");
                end
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule